// File: doc/BRIEF.md
# Pipeline Data-Hazard Controller

This block resolves read-after-write hazards for a five-stage in-order pipeline. For each of the two source registers of the instruction in execute, it compares the register number with the destination held in the execute/memory pipeline register and in the memory/writeback pipeline register. It then drives a two-bit operand select for the datapath mux in front of the ALU. The select picks the newest available copy of the value, so a dependent instruction does not wait for writeback.

A value fetched by a load only exists once the memory stage has finished, so it cannot reach the instruction directly behind the load in time. The block therefore watches the execute-stage instruction. When that instruction is a load whose destination is named by either source of the instruction in decode, the block does two things in the same cycle: it holds the program counter and the fetch/decode register, and it turns the decode/execute register into a no-op bubble. One cycle later the load sits in the memory/writeback register and the normal forwarding path supplies the value. A producer three instructions back needs no path here, because the register file writes in the first half of a cycle and reads in the second.

The block is purely combinational. Its clock and reset are used only by the embedded checks.

Top module: `hazard_ctrl`

## Requirements
- R1: When the execute/memory stage has its write enable set and its non-zero destination equals an execute-stage source, that operand's select is 2'b10.
- R2: When the memory/writeback stage has its write enable set and its non-zero destination equals an execute-stage source, and R1 does not apply to that operand, the select is 2'b01.
- R3: When both later stages match the same source, the execute/memory result wins (select 2'b10).
- R4: A destination of register 0 never causes forwarding, a hold or a bubble.
- R5: A destination match from a stage whose write enable is low is ignored: no forwarding from that stage, and no stall for that execute-stage instruction.
- R6: If the execute-stage instruction has its memory-read flag and its write enable set, and its non-zero destination equals decode source 1 or decode source 2, then hold_o and bubble_o are both 1 in that same cycle.
- R7: No hold or bubble is raised when the execute-stage instruction is not a load, or when it is a load whose destination neither decode source names.
- R8: With no qualifying match, the select is 2'b00 (register file). The value 2'b11 never appears.
- R9: Select A depends only on execute source 1, and select B only on execute source 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the embedded checks only |
| rst_ni | input | 1 | Active-low asynchronous reset, disables the checks |
| id_rs1_i | input | REG_AW | Decode-stage source register 1 |
| id_rs2_i | input | REG_AW | Decode-stage source register 2 |
| ex_rs1_i | input | REG_AW | Execute-stage source register 1 |
| ex_rs2_i | input | REG_AW | Execute-stage source register 2 |
| ex_rd_i | input | REG_AW | Execute-stage destination register |
| ex_we_i | input | 1 | Execute-stage register write enable |
| ex_mem_read_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_AW | Destination in the execute/memory register |
| mem_we_i | input | 1 | Write enable in the execute/memory register |
| wb_rd_i | input | REG_AW | Destination in the memory/writeback register |
| wb_we_i | input | 1 | Write enable in the memory/writeback register |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 writeback |
| fwd_b_o | output | 2 | Operand B select, same encoding |
| hold_o | output | 1 | Hold the PC and the fetch/decode register |
| bubble_o | output | 1 | Load a no-op into the decode/execute register |

## Verification
The bench aims at the case where both later stages hold the same destination. A design with the priority reversed would forward a stale writeback value. It drives destination 0 with write enable set, where a design without the zero guard would forward garbage or stall for no reason. It also drives matches from stages whose write enable is low, which a careless design would treat as real producers. For the interlock, it checks a load followed by a user through source 1 and through source 2 (missing either loses a hazard), a load followed by an independent instruction, and an ALU producer with the same destination; a design that stalls in either of the last two costs a cycle. Random register numbers drawn from a small range make matches frequent across both operands.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int unsigned DEF_REG_AW = 5;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = DEF_REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] rs_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic [1:0]        sel_o
);
  localparam logic [REG_AW-1:0] Zero = '0;

  logic mem_hit, wb_hit;

  assign mem_hit = mem_we_i && (mem_rd_i != Zero) && (mem_rd_i == rs_i);
  assign wb_hit  = wb_we_i  && (wb_rd_i  != Zero) && (wb_rd_i  == rs_i);

  // newest producer first
  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  assert_mem_prio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && rs_i != Zero && mem_rd_i == rs_i && wb_we_i && wb_rd_i == rs_i)
      |-> sel_o == FWD_MEM);
  assert_zero_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_i == Zero) |-> sel_o == FWD_RF);
  assert_we_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_i && !wb_we_i) |-> sel_o == FWD_RF);
  assert_legal_enc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != 2'b11);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned REG_AW = hz_pkg::DEF_REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_mem_read_i,
  output logic              stall_o
);
  localparam logic [REG_AW-1:0] Zero = '0;

  logic is_load, rd_used;

  assign is_load = ex_mem_read_i && ex_we_i && (ex_rd_i != Zero);
  assign rd_used = (ex_rd_i == id_rs1_i) || (ex_rd_i == id_rs2_i);
  assign stall_o = is_load && rd_used;

  assert_zero_dst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == Zero) |-> !stall_o);
  assert_non_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_mem_read_i |-> !stall_o);
  assert_we_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_we_i |-> !stall_o);
  assert_unused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i != id_rs1_i && ex_rd_i != id_rs2_i) |-> !stall_o);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = DEF_REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_mem_read_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              hold_o,
  output logic              bubble_o
);
  localparam int unsigned NumOps = 2;

  logic [NumOps-1:0][REG_AW-1:0] ex_rs;
  logic [NumOps-1:0][1:0]        fwd_sel;
  logic                          stall;

  assign ex_rs[0] = ex_rs1_i;
  assign ex_rs[1] = ex_rs2_i;

  for (genvar g = 0; g < NumOps; g++) begin : g_op
    hz_fwd_sel #(.REG_AW(REG_AW)) i_fwd_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rs_i     (ex_rs[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (fwd_sel[g])
    );
  end

  hz_load_use #(.REG_AW(REG_AW)) i_load_use (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .id_rs1_i      (id_rs1_i),
    .id_rs2_i      (id_rs2_i),
    .ex_rd_i       (ex_rd_i),
    .ex_we_i       (ex_we_i),
    .ex_mem_read_i (ex_mem_read_i),
    .stall_o       (stall)
  );

  assign fwd_a_o  = fwd_sel[0];
  assign fwd_b_o  = fwd_sel[1];
  assign hold_o   = stall;
  assign bubble_o = stall;

  assert_load_use_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_mem_read_i && ex_we_i && ex_rd_i != '0 && ex_rd_i == id_rs1_i)
      |-> (hold_o && bubble_o));
  assert_op_indep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_i == ex_rs2_i) |-> (fwd_a_o == fwd_b_o));
endmodule

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  localparam int unsigned AW = 5;
  localparam int unsigned MaxCycles = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_mr, mem_we, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic hold, bubble;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hazard_ctrl #(.REG_AW(AW)) i_hazard_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_mem_read_i(ex_mr),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .hold_o(hold), .bubble_o(bubble)
  );

  function automatic logic [1:0] exp_sel(logic [AW-1:0] rs);
    if (mem_we && mem_rd != 0 && mem_rd == rs) return 2'b10;
    if (wb_we && wb_rd != 0 && wb_rd == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    return ex_mr && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
  endfunction

  task automatic clear();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
    mem_rd = 0; wb_rd = 0; ex_we = 0; ex_mr = 0; mem_we = 0; wb_we = 0;
  endtask

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  // full comparison against the bench model, sampled mid-cycle
  task automatic check_all(string tag);
    @(negedge clk);
    #1;
    chk({tag, " fwd_a"}, fwd_a, exp_sel(ex_rs1));
    chk({tag, " fwd_b"}, fwd_b, exp_sel(ex_rs2));
    chk({tag, " hold"}, {1'b0, hold}, {1'b0, exp_stall()});
    chk({tag, " bubble"}, {1'b0, bubble}, {1'b0, exp_stall()});
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    #1;
    chk("reset R8 fwd_a", fwd_a, 2'b00);
    chk("reset R8 fwd_b", fwd_b, 2'b00);
    chk("reset R7 hold", {1'b0, hold}, 2'b00);
    rst_n = 1'b1;

    // R1: execute/memory producer to operand A
    clear(); ex_rs1 = 5'd3; mem_rd = 5'd3; mem_we = 1;
    check_all("R1 mem to A");
    chk("R1 fwd_a", fwd_a, 2'b10);

    // R2: writeback producer to operand B
    clear(); ex_rs2 = 5'd7; wb_rd = 5'd7; wb_we = 1;
    check_all("R2 wb to B");
    chk("R2 fwd_b", fwd_b, 2'b01);

    // R3: both stages match
    clear(); ex_rs1 = 5'd9; ex_rs2 = 5'd9; mem_rd = 5'd9; wb_rd = 5'd9;
    mem_we = 1; wb_we = 1;
    check_all("R3 both");
    chk("R3 fwd_a", fwd_a, 2'b10);
    chk("R3 fwd_b", fwd_b, 2'b10);

    // R4: register zero everywhere
    clear(); mem_we = 1; wb_we = 1; ex_we = 1; ex_mr = 1;
    check_all("R4 zero");
    chk("R4 fwd_a", fwd_a, 2'b00);
    chk("R4 hold", {1'b0, hold}, 2'b00);

    // R5: matches with write enable low
    clear(); ex_rs1 = 5'd4; ex_rs2 = 5'd5; mem_rd = 5'd4; wb_rd = 5'd5;
    ex_rd = 5'd6; id_rs1 = 5'd6; ex_mr = 1;
    check_all("R5 no we");
    chk("R5 fwd_a", fwd_a, 2'b00);
    chk("R5 fwd_b", fwd_b, 2'b00);
    chk("R5 hold", {1'b0, hold}, 2'b00);

    // R6: load used through source 1, then through source 2
    clear(); ex_rd = 5'd8; ex_we = 1; ex_mr = 1; id_rs1 = 5'd8; id_rs2 = 5'd2;
    check_all("R6 rs1");
    chk("R6 hold rs1", {1'b0, hold}, 2'b01);
    chk("R6 bubble rs1", {1'b0, bubble}, 2'b01);
    id_rs1 = 5'd2; id_rs2 = 5'd8;
    check_all("R6 rs2");
    chk("R6 hold rs2", {1'b0, hold}, 2'b01);
    // cycle after the bubble: load now in writeback, value forwarded
    clear(); ex_rs2 = 5'd8; wb_rd = 5'd8; wb_we = 1;
    check_all("R6 after");
    chk("R6 fwd_b after", fwd_b, 2'b01);

    // R7: independent follower, and ALU producer with same register
    clear(); ex_rd = 5'd8; ex_we = 1; ex_mr = 1; id_rs1 = 5'd1; id_rs2 = 5'd2;
    check_all("R7 indep");
    chk("R7 hold indep", {1'b0, hold}, 2'b00);
    ex_mr = 0; id_rs1 = 5'd8;
    check_all("R7 alu");
    chk("R7 bubble alu", {1'b0, bubble}, 2'b00);

    // R8: no match at all
    clear(); ex_rs1 = 5'd10; ex_rs2 = 5'd11; mem_rd = 5'd12; wb_rd = 5'd13;
    mem_we = 1; wb_we = 1;
    check_all("R8 none");
    chk("R8 fwd_a", fwd_a, 2'b00);

    // R9: operands differ in their producers
    clear(); ex_rs1 = 5'd14; ex_rs2 = 5'd15; mem_rd = 5'd15; wb_rd = 5'd14;
    mem_we = 1; wb_we = 1;
    check_all("R9 split");
    chk("R9 fwd_a", fwd_a, 2'b01);
    chk("R9 fwd_b", fwd_b, 2'b10);

    // random mix, small register range for frequent matches
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      id_rs1 = AW'($urandom_range(0, 3));
      id_rs2 = AW'($urandom_range(0, 3));
      ex_rs1 = AW'($urandom_range(0, 3));
      ex_rs2 = AW'($urandom_range(0, 3));
      ex_rd  = AW'($urandom_range(0, 3));
      mem_rd = AW'($urandom_range(0, 3));
      wb_rd  = AW'($urandom_range(0, 3));
      ex_we  = 1'($urandom_range(0, 1));
      ex_mr  = 1'($urandom_range(0, 1));
      mem_we = 1'($urandom_range(0, 1));
      wb_we  = 1'($urandom_range(0, 1));
      check_all("random R1 R2 R3 R6 R7");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (MaxCycles) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule